// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns 16-bit segment and offset operands into 20-bit physical byte addresses. The effective address is formed from a combination of a base operand, an index operand and a displacement, chosen by a mode select. The segment operand is shifted left by four bits and added to the effective address. For word accesses the block also gives the address of the upper byte, so a memory interface can split the access into two byte transfers without doing its own arithmetic.

A string mode serves block-move instructions. The source address is formed from the data segment and an internal source pointer. The destination address is formed from a second segment operand and an internal destination pointer. After each element, both pointers step up or down by the element size. The pointers can be loaded from outside, and their values are always visible at the ports. Instruction decode and the general register file are outside the block: the caller presents operand values and a mode code.

All results are registered, with one cycle of latency.

Top module: `segAddrGen`

## Requirements
- R1: While `rstN` is low and after it is released, `outValid` is 0 and both pointers (`srcPtr`, `dstPtr`) read 0.
- R2: For an accepted request, `physAddr` equals `segVal`×16 plus `effAddr`, taken modulo 2^20, and appears on the clock edge that samples the request. `effAddr` is computed modulo 2^16 before the segment is added.
- R3: Mode 0 (direct): `effAddr` equals all 16 bits of `dispVal`, whatever the value of `dispWide`.
- R4: Mode 1 (indirect): `effAddr` equals `baseVal`, which carries the selected pointer or index register.
- R5: Mode 2 (based) gives `baseVal` plus the displacement. Mode 3 (indexed) gives `indexVal` plus the displacement. Both sums wrap modulo 2^16.
- R6: Mode 4 (based-indexed): `effAddr` is `baseVal` plus `indexVal` plus the displacement, modulo 2^16.
- R7: In modes 2 to 4, with `dispWide`=1 the displacement is `dispVal` taken as an unsigned 16-bit value. With `dispWide`=0 it is `dispVal[7:0]` sign-extended to 16 bits.
- R8: When `wordSize`=1, `physAddrHi` is `physAddr`+1 modulo 2^20. When `wordSize`=0 it equals `physAddr`. In string mode the same rule relates `dstAddrHi` to `dstAddr`.
- R9: Mode 5 (string): `effAddr` is the source pointer value before the step. `physAddr` is `segVal`×16 plus that value. `dstAddr` is `extraSeg`×16 plus the destination pointer value before the step. In all other modes, `dstAddr` and `dstAddrHi` read 0.
- R10: After a string request, both pointers change on the same edge. They step by 1 for a byte element and by 2 for a word element. The step is upward when `dirFlag`=0 and downward when `dirFlag`=1, modulo 2^16.
- R11: When `ptrLoad`=1, the pointers take `srcLoad` and `dstLoad` on the next edge, whatever `reqValid` and `modeSel` are. A load overrides a string step in the same cycle, although the string addresses are still produced from the old pointers.
- R12: With `reqValid`=0, or with mode 6 or 7, `outValid` is 0 on the next cycle. In that case the pointers keep their values unless a load is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| modeSel | input | 3 | Addressing mode code (0 to 5 valid) |
| segVal | input | 16 | Segment for the main or source address |
| extraSeg | input | 16 | Segment for the string destination |
| baseVal | input | 16 | Base operand (or pointer operand in indirect mode) |
| indexVal | input | 16 | Index operand |
| dispVal | input | 16 | Displacement or direct offset |
| dispWide | input | 1 | 1: 16-bit unsigned displacement, 0: sign-extended byte |
| wordSize | input | 1 | 1: word access/element, 0: byte |
| dirFlag | input | 1 | String direction, 1 = decrement |
| ptrLoad | input | 1 | Load both string pointers |
| srcLoad | input | 16 | Value loaded into the source pointer |
| dstLoad | input | 16 | Value loaded into the destination pointer |
| outValid | output | 1 | Registered results below are valid |
| effAddr | output | 16 | Effective address |
| physAddr | output | 20 | Physical address of the low byte or source |
| physAddrHi | output | 20 | Physical address of the high byte |
| dstAddr | output | 20 | String destination physical address |
| dstAddrHi | output | 20 | String destination high-byte address |
| srcPtr | output | 16 | Current source pointer |
| dstPtr | output | 16 | Current destination pointer |

## Verification
Every address result, and the matching `outValid`, is due one rising edge after the request is presented. The pointer registers change on that same edge, whether they step or load. The bench drives each request at a falling edge and samples everything at the following falling edge. The expected values come from the pointer state held in the bench model before that edge, and the model is then advanced. Pointer checks after idle or invalid cycles are also taken at the falling edge that follows the cycle.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam logic [2:0] MODE_DIRECT   = 3'd0;
  localparam logic [2:0] MODE_INDIRECT = 3'd1;
  localparam logic [2:0] MODE_BASED    = 3'd2;
  localparam logic [2:0] MODE_INDEXED  = 3'd3;
  localparam logic [2:0] MODE_BASEIDX  = 3'd4;
  localparam logic [2:0] MODE_STRING   = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // register a new result
    logic useBase;    // add base operand
    logic useIndex;   // add index operand
    logic useDisp;    // add displacement
    logic forceWide;  // take displacement as full 16 bits
    logic stringOp;   // string element: use pointers and step them
    logic loadPtr;    // load both pointers
  } ctrlStrobe_t;

endpackage

// File: rtl/segAddrCtrl.sv
module segAddrCtrl
  import seg_addr_pkg::*;
(
  input  logic        reqValid,
  input  logic [2:0]  modeSel,
  input  logic        ptrLoad,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe           = '0;
    strobe.loadPtr   = ptrLoad;
    if (reqValid) begin
      unique case (modeSel)
        MODE_DIRECT: begin
          strobe.capture   = 1'b1;
          strobe.useDisp   = 1'b1;
          strobe.forceWide = 1'b1;
        end
        MODE_INDIRECT: begin
          strobe.capture = 1'b1;
          strobe.useBase = 1'b1;
        end
        MODE_BASED: begin
          strobe.capture = 1'b1;
          strobe.useBase = 1'b1;
          strobe.useDisp = 1'b1;
        end
        MODE_INDEXED: begin
          strobe.capture  = 1'b1;
          strobe.useIndex = 1'b1;
          strobe.useDisp  = 1'b1;
        end
        MODE_BASEIDX: begin
          strobe.capture  = 1'b1;
          strobe.useBase  = 1'b1;
          strobe.useIndex = 1'b1;
          strobe.useDisp  = 1'b1;
        end
        MODE_STRING: begin
          strobe.capture  = 1'b1;
          strobe.stringOp = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/segAddrPtr.sv
module segAddrPtr #(
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [OFFS_W-1:0] loadVal,
  input  logic              stepEn,
  input  logic              dirFlag,
  input  logic              wordSize,
  output logic [OFFS_W-1:0] ptr
);

  logic [OFFS_W-1:0] stepAmt;
  logic [OFFS_W-1:0] ptrNext;

  assign stepAmt = wordSize ? OFFS_W'(2) : OFFS_W'(1);
  assign ptrNext = dirFlag ? (ptr - stepAmt) : (ptr + stepAmt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ptr <= '0;
    else if (loadEn) ptr <= loadVal;
    else if (stepEn) ptr <= ptrNext;
  end

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> ptr == $past(loadVal));

  // R12
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn && !stepEn |=> $stable(ptr));

  // R10
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !loadEn && !dirFlag |=>
      OFFS_W'(ptr - $past(ptr)) == ($past(wordSize) ? OFFS_W'(2) : OFFS_W'(1)));

  // R10
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !loadEn && dirFlag |=>
      OFFS_W'($past(ptr) - ptr) == ($past(wordSize) ? OFFS_W'(2) : OFFS_W'(1)));

endmodule

// File: rtl/segAddrPath.sv
module segAddrPath
  import seg_addr_pkg::*;
#(
  parameter int OFFS_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [OFFS_W-1:0]           segVal,
  input  logic [OFFS_W-1:0]           extraSeg,
  input  logic [OFFS_W-1:0]           baseVal,
  input  logic [OFFS_W-1:0]           indexVal,
  input  logic [OFFS_W-1:0]           dispVal,
  input  logic                        dispWide,
  input  logic                        wordSize,
  input  logic                        dirFlag,
  input  logic [OFFS_W-1:0]           srcLoad,
  input  logic [OFFS_W-1:0]           dstLoad,
  output logic                        outValid,
  output logic [OFFS_W-1:0]           effAddr,
  output logic [OFFS_W+SEG_SHIFT-1:0] physAddr,
  output logic [OFFS_W+SEG_SHIFT-1:0] physAddrHi,
  output logic [OFFS_W+SEG_SHIFT-1:0] dstAddr,
  output logic [OFFS_W+SEG_SHIFT-1:0] dstAddrHi,
  output logic [OFFS_W-1:0]           srcPtr,
  output logic [OFFS_W-1:0]           dstPtr
);

  localparam int PHYS_W  = OFFS_W + SEG_SHIFT;
  localparam int EXT_W   = OFFS_W - SHORT_W;
  localparam int N_CHAN  = 2;

  function automatic logic [PHYS_W-1:0] toPhys(
    input logic [OFFS_W-1:0] seg,
    input logic [OFFS_W-1:0] off
  );
    return ({{SEG_SHIFT{1'b0}}, seg} << SEG_SHIFT) + {{SEG_SHIFT{1'b0}}, off};
  endfunction

  // pointer channels: 0 = source, 1 = destination
  logic [OFFS_W-1:0] chanLoad [N_CHAN];
  logic [OFFS_W-1:0] chanPtr  [N_CHAN];

  assign chanLoad[0] = srcLoad;
  assign chanLoad[1] = dstLoad;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    segAddrPtr #(.OFFS_W(OFFS_W)) i_ptr (
      .clk      (clk),
      .rstN     (rstN),
      .loadEn   (strobe.loadPtr),
      .loadVal  (chanLoad[g]),
      .stepEn   (strobe.stringOp),
      .dirFlag  (dirFlag),
      .wordSize (wordSize),
      .ptr      (chanPtr[g])
    );
  end

  assign srcPtr = chanPtr[0];
  assign dstPtr = chanPtr[1];

  // effective address arithmetic
  logic [OFFS_W-1:0] dispExt;
  logic [OFFS_W-1:0] baseTerm;
  logic [OFFS_W-1:0] indexTerm;
  logic [OFFS_W-1:0] dispTerm;
  logic [OFFS_W-1:0] eaSum;
  logic [OFFS_W-1:0] eaNow;
  logic [PHYS_W-1:0] physNow;
  logic [PHYS_W-1:0] physHiNow;
  logic [PHYS_W-1:0] dstNow;
  logic [PHYS_W-1:0] dstHiNow;

  always_comb begin
    if (dispWide || strobe.forceWide) dispExt = dispVal;
    else dispExt = {{EXT_W{dispVal[SHORT_W-1]}}, dispVal[SHORT_W-1:0]};
    baseTerm  = strobe.useBase  ? baseVal  : '0;
    indexTerm = strobe.useIndex ? indexVal : '0;
    dispTerm  = strobe.useDisp  ? dispExt  : '0;
    eaSum     = baseTerm + indexTerm + dispTerm;
    eaNow     = strobe.stringOp ? chanPtr[0] : eaSum;
    physNow   = toPhys(segVal, eaNow);
    physHiNow = wordSize ? physNow + PHYS_W'(1) : physNow;
    if (strobe.stringOp) begin
      dstNow   = toPhys(extraSeg, chanPtr[1]);
      dstHiNow = wordSize ? dstNow + PHYS_W'(1) : dstNow;
    end else begin
      dstNow   = '0;
      dstHiNow = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      effAddr    <= '0;
      physAddr   <= '0;
      physAddrHi <= '0;
      dstAddr    <= '0;
      dstAddrHi  <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        effAddr    <= eaNow;
        physAddr   <= physNow;
        physAddrHi <= physHiNow;
        dstAddr    <= dstNow;
        dstAddrHi  <= dstHiNow;
      end
    end
  end

  // R2
  phys_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> physAddr[SEG_SHIFT-1:0] == effAddr[SEG_SHIFT-1:0]);

  // R8
  byte_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(wordSize) |-> physAddrHi == physAddr && dstAddrHi == dstAddr);

  // R9
  dst_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(strobe.stringOp) |-> dstAddr == '0 && dstAddrHi == '0);

  // R9
  str_ea_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(strobe.stringOp) |-> effAddr == $past(srcPtr));

endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import seg_addr_pkg::*;
#(
  parameter int OFFS_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [2:0]                  modeSel,
  input  logic [OFFS_W-1:0]           segVal,
  input  logic [OFFS_W-1:0]           extraSeg,
  input  logic [OFFS_W-1:0]           baseVal,
  input  logic [OFFS_W-1:0]           indexVal,
  input  logic [OFFS_W-1:0]           dispVal,
  input  logic                        dispWide,
  input  logic                        wordSize,
  input  logic                        dirFlag,
  input  logic                        ptrLoad,
  input  logic [OFFS_W-1:0]           srcLoad,
  input  logic [OFFS_W-1:0]           dstLoad,
  output logic                        outValid,
  output logic [OFFS_W-1:0]           effAddr,
  output logic [OFFS_W+SEG_SHIFT-1:0] physAddr,
  output logic [OFFS_W+SEG_SHIFT-1:0] physAddrHi,
  output logic [OFFS_W+SEG_SHIFT-1:0] dstAddr,
  output logic [OFFS_W+SEG_SHIFT-1:0] dstAddrHi,
  output logic [OFFS_W-1:0]           srcPtr,
  output logic [OFFS_W-1:0]           dstPtr
);

  ctrlStrobe_t strobe;

  segAddrCtrl i_ctrl (
    .reqValid (reqValid),
    .modeSel  (modeSel),
    .ptrLoad  (ptrLoad),
    .strobe   (strobe)
  );

  segAddrPath #(
    .OFFS_W    (OFFS_W),
    .SEG_SHIFT (SEG_SHIFT),
    .SHORT_W   (SHORT_W)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .segVal     (segVal),
    .extraSeg   (extraSeg),
    .baseVal    (baseVal),
    .indexVal   (indexVal),
    .dispVal    (dispVal),
    .dispWide   (dispWide),
    .wordSize   (wordSize),
    .dirFlag    (dirFlag),
    .srcLoad    (srcLoad),
    .dstLoad    (dstLoad),
    .outValid   (outValid),
    .effAddr    (effAddr),
    .physAddr   (physAddr),
    .physAddrHi (physAddrHi),
    .dstAddr    (dstAddr),
    .dstAddrHi  (dstAddrHi),
    .srcPtr     (srcPtr),
    .dstPtr     (dstPtr)
  );

  // R12
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid) && ($past(modeSel) <= MODE_STRING));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> !outValid && srcPtr == '0 && dstPtr == '0);

endmodule

// File: tb/test_segAddrGen.sv
`timescale 1ns/100ps
module test_segAddrGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  modeSel = '0;
  logic [15:0] segVal = '0, extraSeg = '0, baseVal = '0, indexVal = '0, dispVal = '0;
  logic        dispWide = 1'b0, wordSize = 1'b0, dirFlag = 1'b0, ptrLoad = 1'b0;
  logic [15:0] srcLoad = '0, dstLoad = '0;
  logic        outValid;
  logic [15:0] effAddr, srcPtr, dstPtr;
  logic [19:0] physAddr, physAddrHi, dstAddr, dstAddrHi;

  int vecCount = 0;
  int missCount = 0;
  logic [15:0] mSrc = '0, mDst = '0;

  always #2.5 clk = ~clk;

  segAddrGen i_segAddrGen (
    .clk, .rstN, .reqValid, .modeSel, .segVal, .extraSeg, .baseVal, .indexVal,
    .dispVal, .dispWide, .wordSize, .dirFlag, .ptrLoad, .srcLoad, .dstLoad,
    .outValid, .effAddr, .physAddr, .physAddrHi, .dstAddr, .dstAddrHi,
    .srcPtr, .dstPtr
  );

  function automatic logic [19:0] physOf(input logic [15:0] seg, input logic [15:0] off);
    return ({4'h0, seg} << 4) + {4'h0, off};
  endfunction

  function automatic logic [15:0] dispOf(input logic [15:0] d, input logic wide);
    return wide ? d : {{8{d[7]}}, d[7:0]};
  endfunction

  function automatic logic [15:0] eaOf(input logic [2:0] m, input logic [15:0] b,
      input logic [15:0] x, input logic [15:0] d, input logic wide, input logic [15:0] sp);
    case (m)
      3'd0: return d;
      3'd1: return b;
      3'd2: return b + dispOf(d, wide);
      3'd3: return x + dispOf(d, wide);
      3'd4: return b + x + dispOf(d, wide);
      default: return sp;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
  endtask

  // drive one cycle at a falling edge, sample at the next falling edge
  task automatic apply(input logic rv, input logic [2:0] m, input logic [15:0] sg,
      input logic [15:0] es, input logic [15:0] b, input logic [15:0] x,
      input logic [15:0] d, input logic wide, input logic ws, input logic df,
      input logic ld, input logic [15:0] sl, input logic [15:0] dl, input string tag);
    logic        expValid;
    logic [15:0] expEa, step;
    logic [19:0] expPhys, expHi, expDst, expDstHi;
    reqValid = rv; modeSel = m; segVal = sg; extraSeg = es; baseVal = b;
    indexVal = x; dispVal = d; dispWide = wide; wordSize = ws; dirFlag = df;
    ptrLoad = ld; srcLoad = sl; dstLoad = dl;
    expValid = rv && (m <= 3'd5);
    expEa    = eaOf(m, b, x, d, wide, mSrc);
    expPhys  = physOf(sg, expEa);
    expHi    = ws ? expPhys + 20'd1 : expPhys;
    expDst   = (m == 3'd5) ? physOf(es, mDst) : 20'h0;
    expDstHi = (m == 3'd5 && ws) ? expDst + 20'd1 : expDst;
    step = ws ? 16'd2 : 16'd1;
    if (ld) begin
      mSrc = sl; mDst = dl;
    end else if (rv && m == 3'd5) begin
      mSrc = df ? mSrc - step : mSrc + step;
      mDst = df ? mDst - step : mDst + step;
    end
    @(negedge clk);
    chk({tag, " R12 outValid"}, {31'h0, outValid}, {31'h0, expValid});
    if (expValid) begin
      chk({tag, " R2 effAddr"}, {16'h0, effAddr}, {16'h0, expEa});
      chk({tag, " R2 physAddr"}, {12'h0, physAddr}, {12'h0, expPhys});
      chk({tag, " R8 physAddrHi"}, {12'h0, physAddrHi}, {12'h0, expHi});
      chk({tag, " R9 dstAddr"}, {12'h0, dstAddr}, {12'h0, expDst});
      chk({tag, " R8 dstAddrHi"}, {12'h0, dstAddrHi}, {12'h0, expDstHi});
    end
    chk({tag, " R10 srcPtr"}, {16'h0, srcPtr}, {16'h0, mSrc});
    chk({tag, " R10 dstPtr"}, {16'h0, dstPtr}, {16'h0, mDst});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid in reset", {31'h0, outValid}, 32'h0);
    chk("R1 srcPtr in reset", {16'h0, srcPtr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", {31'h0, outValid}, 32'h0);
    chk("R1 dstPtr after reset", {16'h0, dstPtr}, 32'h0);

    // R3: direct, narrow flag ignored
    apply(1, 3'd0, 16'h3050, 16'h0, 16'h1111, 16'h2222, 16'h0040, 0, 0, 0, 0, 0, 0, "R3 direct");
    apply(1, 3'd0, 16'h1000, 16'h0, 16'h0, 16'h0, 16'h00F0, 0, 0, 0, 0, 0, 0, "R3 direct narrowflag");
    // R4: indirect
    apply(1, 3'd1, 16'h5004, 16'h0, 16'h0020, 16'h9999, 16'h7777, 1, 1, 0, 0, 0, 0, "R4 indirect word");
    // R5 / R7: based with sign-extended byte
    apply(1, 3'd2, 16'h0000, 16'h0, 16'h0100, 16'h0, 16'h12F0, 0, 0, 0, 0, 0, 0, "R5 R7 based negdisp");
    apply(1, 3'd3, 16'h0000, 16'h0, 16'h0, 16'hFFF0, 16'h0020, 1, 0, 0, 0, 0, 0, "R5 R7 indexed wrap");
    // R6: based-indexed
    apply(1, 3'd4, 16'h3000, 16'h0, 16'h0200, 16'h1000, 16'h0008, 0, 0, 0, 0, 0, 0, "R6 baseidx");
    // R2: physical wrap; R8: high byte wrap
    apply(1, 3'd0, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1, 0, 0, 0, 0, 0, "R2 phys wrap");
    apply(1, 3'd0, 16'hF000, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1, 1, 0, 0, 0, 0, "R8 hi wrap");
    // R11 load, then R9/R10 string byte increment
    apply(0, 3'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 1, 16'h0500, 16'h0300, "R11 load");
    apply(1, 3'd5, 16'h2000, 16'h4000, 16'h0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, "R9 R10 string byte up");
    apply(1, 3'd5, 16'h2000, 16'h4000, 16'h0, 16'h0, 16'h0, 0, 1, 1, 0, 0, 0, "R10 string word down");
    // R10: decrement wraps below zero
    apply(0, 3'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 1, 16'h0000, 16'h0001, "R11 load low");
    apply(1, 3'd5, 16'h0100, 16'h0200, 16'h0, 16'h0, 16'h0, 0, 1, 1, 0, 0, 0, "R10 down wrap");
    // R11: load wins over step
    apply(1, 3'd5, 16'h0100, 16'h0200, 16'h0, 16'h0, 16'h0, 0, 1, 0, 1, 16'hABCD, 16'h1234, "R11 load over step");
    // R12: invalid modes and idle keep pointers
    apply(1, 3'd6, 16'h1234, 16'h0, 16'h0, 16'h0, 16'h0, 0, 1, 0, 0, 0, 0, "R12 mode6");
    apply(1, 3'd7, 16'h1234, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 1, 0, 0, 0, "R12 mode7");
    apply(0, 3'd5, 16'h1234, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, "R12 idle string");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      apply(($urandom % 8) != 0, 3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
            16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 6) == 0, 16'($urandom), 16'($urandom), "random");
    end

    summary();
    $finish;
  end

endmodule